// File: doc/BRIEF.md
# Unrolled CORDIC Vectoring Arctangent

This block returns the phase angle of a signed complex sample (x, y), that is atan2(y, x), over the full circle. It is meant for phase detectors in carrier tracking loops, where the angle between a received sample and its nearest decision point feeds a loop filter. The angle comes from a chain of shift-and-add micro-rotations. Each one turns the vector towards the positive real axis and adds a constant arctangent term to a running angle that starts at zero.

Micro-rotations only converge within a quarter turn of the real axis. A coarse stage therefore first turns any left-half-plane input by a quarter turn into the right half-plane and records which way it turned. A quarter turn in the matching direction is added to the angle after the last micro-rotation. Every shift amount and arctangent constant is fixed by the stage's position in the chain, so the chain needs no barrel shifter and no table. One parameter sets the number of micro-rotations. A second sets how many register slices are spread along the chain. The default of zero gives a purely combinational path with no delay in a feedback loop. The valid strobe passes through the same slices as the data.

The output angle is a signed two's-complement number. The value v stands for v·π/2^(ANG_W−1), so +π and −π share the code −2^(ANG_W−1), and the angle wraps modulo 2^ANG_W. Only the ratio y/x matters, so inputs in any fixed-point format give the same angle.

Top module: `cordic_vector_atan`

## Requirements
- R1: For inputs in the right half-plane (in_x ≥ 0), out_angle equals atan2(in_y, in_x)·2^(ANG_W−1)/π. The result is within atan(2^−(ITERS−1))·2^(ANG_W−1)/π + 48 codes, measured modulo 2^ANG_W.
- R2: For inputs with in_x < 0 and in_y ≠ 0, out_angle meets the same bound as R1, covering the second and third quadrants.
- R3: Each micro-rotation turns clockwise (adding its arctangent term) when the running y is non-negative, and counter-clockwise (subtracting the term) when it is negative. Inputs with in_y < 0 and in_x ≥ 0 therefore give negative angles within the R1 bound, and the running x never goes negative.
- R4: When in_x < 0, the coarse stage rotates by −π/2 if in_y ≥ 0 and by +π/2 if in_y < 0. It then adds the matching ±π/2 after the chain. Inputs on the negative real axis (in_y = 0) give an angle within the R1 bound of ±π.
- R5: Raising ITERS tightens the bound: with ITERS = 8, every case meets the R1 formula evaluated for 8 iterations.
- R6: The latency from inputs to out_angle is exactly PIPE_REGS clock cycles, for 0 ≤ PIPE_REGS ≤ ITERS + 1. With PIPE_REGS = 0 the output follows the inputs in the same cycle.
- R7: out_valid is in_valid delayed by PIPE_REGS cycles. When PIPE_REGS > 0, reset clears every delayed valid, so out_valid is 0 during reset and for the first PIPE_REGS cycles after it.
- R8: Full-scale inputs, including −2^(IN_W−1) on either or both axes, give the correct angle within the R1 bound with no internal overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline slices |
| rst_n | input | 1 | Asynchronous active-low reset of the slices |
| in_valid | input | 1 | Marks a sample on in_x / in_y |
| in_x | input | IN_W | Real part, signed two's complement |
| in_y | input | IN_W | Imaginary part, signed two's complement |
| out_valid | output | 1 | in_valid delayed by PIPE_REGS cycles |
| out_angle | output | ANG_W | Angle, signed, v means v·π/2^(ANG_W−1) |

## Verification
A wrong micro-rotation sign, a wrong arctangent constant or a swapped quadrant correction moves the angle by at least the smallest arctangent term, usually by a quarter turn or more. Such a fault therefore shows up at out_angle on the first affected sample, in the cycle its result emerges. A misplaced or missing pipeline slice shifts every result and valid strobe by one cycle, so a stream of distinct angles exposes it at once. The bench sweeps two radii around the full circle, plus the axes and the full-scale corners. It runs three configurations side by side: combinational, four slices, and eight iterations.

// File: rtl/cva_pkg.sv
package cva_pkg;

    // Quarter-turn correction that the coarse stage leaves for the tail.
    typedef enum logic [1:0] {
        QF_NONE     = 2'b00,
        QF_ADD_HALF = 2'b01,
        QF_SUB_HALF = 2'b10
    } quad_fix_e;

    localparam real PI_R = 3.14159265358979323846;

    // arctan(2^-step) in angle codes where pi maps to 2^(ang_w-1).
    function automatic longint atan_units(input int step, input int ang_w);
        real r;
        r = $atan(2.0 ** (-step)) / PI_R * (2.0 ** (ang_w - 1));
        return longint'($rtoi(r + 0.5));
    endfunction

    // Spread n_regs register slices evenly over n_bound stage boundaries.
    function automatic bit boundary_reg(input int k, input int n_regs, input int n_bound);
        return ((k + 1) * n_regs) / n_bound != (k * n_regs) / n_bound;
    endfunction

endpackage

// File: rtl/cordic_coarse_map.sv
module cordic_coarse_map
    import cva_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int IW      = 18,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] y_i,
    output logic                 v_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output quad_fix_e            q_o
);

    localparam int EXT = IW - IN_W;

    logic signed [IW-1:0] xe, ye;
    logic signed [IW-1:0] xm, ym;
    quad_fix_e            qm;

    assign xe = {{EXT{x_i[IN_W-1]}}, x_i};
    assign ye = {{EXT{y_i[IN_W-1]}}, y_i};

    // Left half-plane: turn a quarter towards the positive real axis.
    always_comb begin
        if (!xe[IW-1]) begin
            xm = xe;
            ym = ye;
            qm = QF_NONE;
        end else if (!ye[IW-1]) begin
            xm = ye;
            ym = -xe;
            qm = QF_ADD_HALF;
        end else begin
            xm = -ye;
            ym = xe;
            qm = QF_SUB_HALF;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            logic                 v_q;
            logic signed [IW-1:0] x_q, y_q;
            quad_fix_e            q_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    x_q <= '0;
                    y_q <= '0;
                    q_q <= QF_NONE;
                end else begin
                    v_q <= v_i;
                    x_q <= xm;
                    y_q <= ym;
                    q_q <= qm;
                end
            end
            assign v_o = v_q;
            assign x_o = x_q;
            assign y_o = y_q;
            assign q_o = q_q;
        end else begin : g_comb
            assign v_o = v_i;
            assign x_o = xm;
            assign y_o = ym;
            assign q_o = qm;
        end
    endgenerate

    // R4: the mapped vector always lies in the right half-plane.
    assert_right_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xm[IW-1]);

endmodule

// File: rtl/cordic_micro_stage.sv
module cordic_micro_stage
    import cva_pkg::*;
#(
    parameter int IW      = 18,
    parameter int AW      = 16,
    parameter int STEP    = 0,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [AW-1:0] z_i,
    input  quad_fix_e            q_i,
    output logic                 v_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [AW-1:0] z_o,
    output quad_fix_e            q_o
);

    localparam logic signed [AW-1:0] ANG_STEP = AW'(atan_units(STEP, AW));

    logic signed [IW-1:0] x_n, y_n;
    logic signed [AW-1:0] z_n;

    // Direction follows the sign of the running y, pushing it towards zero.
    always_comb begin
        if (!y_i[IW-1]) begin
            x_n = x_i + (y_i >>> STEP);
            y_n = y_i - (x_i >>> STEP);
            z_n = z_i + ANG_STEP;
        end else begin
            x_n = x_i - (y_i >>> STEP);
            y_n = y_i + (x_i >>> STEP);
            z_n = z_i - ANG_STEP;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            logic                 v_q, past_ok;
            logic signed [IW-1:0] x_q, y_q;
            logic signed [AW-1:0] z_q;
            quad_fix_e            q_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q     <= 1'b0;
                    x_q     <= '0;
                    y_q     <= '0;
                    z_q     <= '0;
                    q_q     <= QF_NONE;
                    past_ok <= 1'b0;
                end else begin
                    v_q     <= v_i;
                    x_q     <= x_n;
                    y_q     <= y_n;
                    z_q     <= z_n;
                    q_q     <= q_i;
                    past_ok <= 1'b1;
                end
            end
            assign v_o = v_q;
            assign x_o = x_q;
            assign y_o = y_q;
            assign z_o = z_q;
            assign q_o = q_q;

            // R7: a registered slice delays the valid strobe by one cycle.
            assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok |-> (v_o == $past(v_i)));
        end else begin : g_comb
            assign v_o = v_i;
            assign x_o = x_n;
            assign y_o = y_n;
            assign z_o = z_n;
            assign q_o = q_i;
        end
    endgenerate

    // R3: a non-negative running x stays non-negative through a micro-rotation.
    assert_x_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !x_i[IW-1] |-> !x_n[IW-1]);

endmodule

// File: rtl/cordic_quad_fix.sv
module cordic_quad_fix
    import cva_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [AW-1:0] z_i,
    input  quad_fix_e            q_i,
    output logic                 v_o,
    output logic signed [AW-1:0] angle_o
);

    localparam logic signed [AW-1:0] HALF_PI = {2'b01, {(AW-2){1'b0}}};

    logic signed [AW-1:0] offset;

    always_comb begin
        unique case (q_i)
            QF_NONE:     offset = '0;
            QF_ADD_HALF: offset = HALF_PI;
            QF_SUB_HALF: offset = -HALF_PI;
            default:     offset = '0;
        endcase
    end

    assign angle_o = z_i + offset;
    assign v_o     = v_i;

    // R4: at most one quarter-turn correction is ever requested.
    assert_quad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_i));

endmodule

// File: rtl/cordic_vector_atan.sv
module cordic_vector_atan
    import cva_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int ANG_W     = 16,
    parameter int ITERS     = 5,
    parameter int PIPE_REGS = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_x,
    input  logic signed [IN_W-1:0]  in_y,
    output logic                    out_valid,
    output logic signed [ANG_W-1:0] out_angle
);

    // Two guard bits: one for the quarter-turn negation, one for CORDIC gain.
    localparam int IW = IN_W + 2;
    localparam int NB = ITERS + 1;

    logic                    sv [0:ITERS];
    logic signed [IW-1:0]    sx [0:ITERS];
    logic signed [IW-1:0]    sy [0:ITERS];
    logic signed [ANG_W-1:0] sz [0:ITERS];
    quad_fix_e               sq [0:ITERS];

    // Running angle starts at zero; the coarse turn is settled at the tail.
    assign sz[0] = '0;

    cordic_coarse_map #(
        .IN_W    (IN_W),
        .IW      (IW),
        .REG_OUT (boundary_reg(0, PIPE_REGS, NB))
    ) u_coarse (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .x_i   (in_x),
        .y_i   (in_y),
        .v_o   (sv[0]),
        .x_o   (sx[0]),
        .y_o   (sy[0]),
        .q_o   (sq[0])
    );

    generate
        for (genvar i = 0; i < ITERS; i++) begin : g_stage
            cordic_micro_stage #(
                .IW      (IW),
                .AW      (ANG_W),
                .STEP    (i),
                .REG_OUT (boundary_reg(i + 1, PIPE_REGS, NB))
            ) u_micro (
                .clk   (clk),
                .rst_n (rst_n),
                .v_i   (sv[i]),
                .x_i   (sx[i]),
                .y_i   (sy[i]),
                .z_i   (sz[i]),
                .q_i   (sq[i]),
                .v_o   (sv[i+1]),
                .x_o   (sx[i+1]),
                .y_o   (sy[i+1]),
                .z_o   (sz[i+1]),
                .q_o   (sq[i+1])
            );
        end
    endgenerate

    cordic_quad_fix #(
        .AW (ANG_W)
    ) u_fix (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_i     (sv[ITERS]),
        .z_i     (sz[ITERS]),
        .q_i     (sq[ITERS]),
        .v_o     (out_valid),
        .angle_o (out_angle)
    );

    // R3 / R8: the vector leaving the chain remains in the right half-plane.
    assert_final_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sx[ITERS][IW-1]);

endmodule

// File: tb/tb_cordic_vector_atan.sv
`timescale 1ns/1ps
module tb_cordic_vector_atan;

    localparam int  W  = 16;
    localparam int  AW = 16;
    localparam int  NV = 150;
    localparam int  LAT = 4;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_x = '0;
    logic signed [W-1:0] in_y = '0;

    logic v_c, v_p, v_f;
    logic signed [AW-1:0] a_c, a_p, a_f;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int vx [NV];
    int vy [NV];
    bit vv [NV];
    int nv = 0;

    always #2.5 clk = ~clk;

    cordic_vector_atan #(.IN_W(W), .ANG_W(AW), .ITERS(5), .PIPE_REGS(0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(v_c), .out_angle(a_c));

    cordic_vector_atan #(.IN_W(W), .ANG_W(AW), .ITERS(5), .PIPE_REGS(LAT)) dut_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(v_p), .out_angle(a_p));

    cordic_vector_atan #(.IN_W(W), .ANG_W(AW), .ITERS(8), .PIPE_REGS(0)) dut_fine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(v_f), .out_angle(a_f));

    function automatic int ref_angle(int x, int y);
        real r;
        r = $atan2(real'(y), real'(x)) / PI * 32768.0;
        return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
    endfunction

    function automatic int wrap_diff(int a, int b);
        int d;
        d = a - b;
        d = (((d + 32768) % 65536) + 65536) % 65536 - 32768;
        return d;
    endfunction

    function automatic int tolerance(int iters);
        return $rtoi($atan(2.0 ** (-(iters - 1))) / PI * 32768.0) + 48;
    endfunction

    function automatic string tag_of(int idx);
        if (idx >= nv - 6) return "R8";
        if (vx[idx] < 0 && vy[idx] == 0) return "R4";
        if (vx[idx] < 0) return "R2";
        if (vy[idx] < 0) return "R3";
        return "R1";
    endfunction

    task automatic check_angle(string tag, int act, int x, int y, int iters);
        int e, d, t;
        e = ref_angle(x, y);
        d = wrap_diff(act, e);
        t = tolerance(iters);
        n_tests++;
        if (d > t || d < -t) begin
            n_fail++;
            $display("FAIL %s angle of (%0d,%0d): actual %0d expected %0d (tol %0d)",
                     tag, x, y, act, e, t);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s valid: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic add_vec(int x, int y);
        vx[nv] = x;
        vy[nv] = y;
        vv[nv] = (nv % 3) != 1;
        nv++;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Stimulus: two radii around the circle, the axes, full-scale corners last.
        for (int i = 0; i < 64; i++) begin
            real th;
            th = 2.0 * PI * real'(i) / 64.0 + 0.013;
            add_vec($rtoi(20000.0 * $cos(th)), $rtoi(20000.0 * $sin(th)));
        end
        for (int i = 0; i < 48; i++) begin
            real th;
            th = 2.0 * PI * real'(i) / 48.0 + 0.29;
            add_vec($rtoi(3000.0 * $cos(th)), $rtoi(3000.0 * $sin(th)));
        end
        add_vec(25000, 0);
        add_vec(0, 25000);
        add_vec(0, -25000);
        add_vec(-25000, 0);
        add_vec(-32768, 0);
        add_vec(-32768, -32768);
        add_vec(-32768, 32767);
        add_vec(32767, -32768);
        add_vec(0, -32768);
        add_vec(32767, 32767);

        // R7: delayed valids are cleared during reset even with in_valid high.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R7 reset", v_p, 1'b0);
        check_bit("R6 comb valid", v_c, 1'b1);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int k = 0; k < nv + LAT; k++) begin
            @(negedge clk);
            if (k < nv) begin
                in_x = W'(vx[k]);
                in_y = W'(vy[k]);
                in_valid = vv[k];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (k < nv) begin
                check_angle(tag_of(k), int'(a_c), vx[k], vy[k], 5);
                check_angle("R5", int'(a_f), vx[k], vy[k], 8);
                check_bit("R6 comb valid", v_c, vv[k]);
            end
            if (k >= LAT) begin
                check_angle("R6", int'(a_p), vx[k-LAT], vy[k-LAT], 5);
                check_bit("R7", v_p, vv[k-LAT]);
            end else begin
                check_bit("R7 after reset", v_p, 1'b0);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule